// File: doc/BRIEF.md
# Four-Channel Bus-Hold DMA Controller

This block moves bytes for up to four peripherals over a system bus that it borrows from the CPU. Software programs each channel with a source address, a destination address, a byte count and a transfer mode, then sets the channel's enable bit. When an enabled channel's peripheral raises its request, the controller raises `hold_req` and waits. It drives nothing on the bus until the CPU answers with `hold_ack`. Each bus cycle in which a byte moves is marked by `xfer_stb`. In that cycle the channel's current source and destination addresses appear on `src_addr` and `dst_addr`, and the peripheral's acknowledge line in `dack` is high.

There are three modes. Single mode moves one byte per grant and then drops `hold_req` for a cycle, so the CPU and the controller share the bus on alternate tenures. Block mode moves the whole count in one tenure of back-to-back cycles. Demand mode moves a byte in every cycle that the peripheral keeps its request high, and gives the bus back when the request falls. When requests arrive together, the lowest-numbered channel wins. When a channel's count runs out, the channel pulses `done`, disables itself and stops asking for the bus.

The sequencer has four states. `ST_IDLE` means the bus is not requested. `ST_REQ` holds `hold_req` high while waiting for the acknowledge, and picks the winning channel. `ST_XFER` owns the bus and moves bytes. `ST_YIELD` is the one released cycle after a single-mode byte. The transitions are as follows. `ST_IDLE` goes to `ST_REQ` when any channel is pending. `ST_REQ` goes to `ST_XFER` when `hold_ack` is high and a channel is pending, and back to `ST_IDLE` when nothing is pending any more. `ST_XFER` goes to `ST_REQ` if `hold_ack` falls. In single mode it goes from `ST_XFER` to `ST_YIELD`. In block mode it stays in `ST_XFER` until terminal count. In demand mode it stays in `ST_XFER` while the request stays high and the count has not run out. When a block or demand channel stops, `ST_XFER` goes to `ST_REQ` if another channel is pending and to `ST_IDLE` if none is. `ST_YIELD` goes to `ST_REQ` if any channel is pending and to `ST_IDLE` otherwise.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset all channels are disabled, and `hold_req`, `xfer_stb`, `dack` and `done` are all low. A peripheral request to a channel that has never been enabled does not raise `hold_req`.
- R2: `xfer_stb` and any bit of `dack` are high only in cycles where both `hold_req` and `hold_ack` are high. While `hold_ack` stays low, no byte moves and `src_addr` and `dst_addr` stay zero.
- R3: A register write selects a channel with `cfg_chan` and a field with `cfg_sel`. The field codes are 0 for the source address, 1 for the destination address, 2 for the count (the low count-width bits of `cfg_data`) and 3 for control. In the control field, bit 0 is enable and bits 2:1 are the mode: 00 single, 01 block, 10 demand, 11 treated as single. A write takes effect only when the sequencer is in `ST_IDLE` and the target channel is disabled; any other write is ignored. Setting enable with a count of zero leaves the channel disabled.
- R4: A channel is pending when it is enabled and its `dreq` bit is high. When the bus is granted, the lowest-numbered pending channel is served first.
- R5: Each moved byte shows the channel's current source and destination addresses on `src_addr` and `dst_addr`, with exactly one `dack` bit high. Both addresses then increase by one, wrapping at the address width, and the count decreases by one.
- R6: In single mode, exactly one byte moves per grant. `hold_req` is low in the cycle after each moved byte.
- R7: In block mode, all bytes of the count move on consecutive cycles. Once the first byte has moved, the channel's `dreq` no longer has any effect.
- R8: In demand mode, bytes move on consecutive cycles while `dreq` stays high, and no byte moves in a cycle where it is low. When `dreq` falls and no other channel is pending, `hold_req` drops. The remaining count resumes on the next request.
- R9: The byte that takes the count from 1 to 0 carries a one-cycle `done` pulse for that channel in its own cycle. The channel then becomes disabled, and a `dreq` held high afterwards gets no further service.
- R10: `dack` is one-hot or zero, and is nonzero exactly when `xfer_stb` is high. `done` is never high without the matching `dack` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | CH_W | Channel selected for the write |
| cfg_sel | input | 2 | Field code: 0 source, 1 destination, 2 count, 3 control |
| cfg_data | input | ADDR_W | Write data |
| dreq | input | NCH | Peripheral request, one bit per channel |
| hold_ack | input | 1 | CPU grants the bus |
| hold_req | output | 1 | Controller asks for the bus |
| xfer_stb | output | 1 | A byte moves in this cycle |
| dack | output | NCH | Per-channel transfer acknowledge |
| done | output | NCH | Per-channel terminal-count pulse |
| src_addr | output | ADDR_W | Source address of the moving byte, zero otherwise |
| dst_addr | output | ADDR_W | Destination address of the moving byte, zero otherwise |

## Verification
The assertions check these properties on every cycle: no byte moves without the handshake, the acknowledge is one-hot, done is only ever seen with an acknowledge, single mode releases the bus after each byte, demand bytes occur only with the request high, and each byte lowers the count by one and clears the enable at terminal count. Only the bench scenarios can show the rest. These are the full address sequences against a model of the programmed values, the service order of simultaneous requests, block runs that ignore a dropped request, a demand run that pauses and resumes, and register writes that are ignored because the channel is active or the bus is busy.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_BLOCK  = 2'd1,
        MODE_DEMAND = 2'd2,
        MODE_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        FLD_SRC  = 2'd0,
        FLD_DST  = 2'd1,
        FLD_CNT  = 2'd2,
        FLD_CTRL = 2'd3
    } cfg_field_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_XFER  = 2'd2,
        ST_YIELD = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma4_chan.sv
`timescale 1ns/1ps
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              en_q,
    output xfer_mode_e        mode_q,
    output logic              last
);
    assign last = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            en_q   <= 1'b0;
            mode_q <= MODE_SINGLE;
        end else if (wr_en) begin
            unique case (cfg_field_e'(wr_sel))
                FLD_SRC:  src_q <= wr_data;
                FLD_DST:  dst_q <= wr_data;
                FLD_CNT:  cnt_q <= wr_data[CNT_W-1:0];
                FLD_CTRL: begin
                    en_q   <= wr_data[0] && (cnt_q != '0);
                    mode_q <= xfer_mode_e'(wr_data[2:1]);
                end
            endcase
        end else if (step) begin
            src_q <= src_q + 1'b1;
            dst_q <= dst_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
            if (last) begin
                en_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma4_prio.sv
`timescale 1ns/1ps
module dma4_prio #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  req,
    output logic            any,
    output logic [CH_W-1:0] idx
);
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma4_seq.sv
`timescale 1ns/1ps
module dma4_seq
    import dma4_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  pend,
    input  logic            win_any,
    input  logic [CH_W-1:0] win_idx,
    input  logic            hold_ack,
    input  logic            cur_dreq,
    input  xfer_mode_e      cur_mode,
    input  logic            cur_last,
    output logic            hold_req,
    output logic            move,
    output logic            idle,
    output logic [CH_W-1:0] cur_q
);
    seq_state_e state, nxt;
    logic [NCH-1:0] pend_rest;
    logic           rest_any;

    assign pend_rest = pend & ~(NCH'(1) << cur_q);
    assign rest_any  = |pend_rest;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_REQ && hold_ack && win_any) begin
                cur_q <= win_idx;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (win_any) nxt = ST_REQ;
            end
            ST_REQ: begin
                if (!win_any)     nxt = ST_IDLE;
                else if (hold_ack) nxt = ST_XFER;
            end
            ST_XFER: begin
                if (!hold_ack) begin
                    nxt = ST_REQ;
                end else begin
                    case (cur_mode)
                        MODE_BLOCK: begin
                            if (cur_last) nxt = rest_any ? ST_REQ : ST_IDLE;
                            else          nxt = ST_XFER;
                        end
                        MODE_DEMAND: begin
                            if (!cur_dreq || cur_last) nxt = rest_any ? ST_REQ : ST_IDLE;
                            else                       nxt = ST_XFER;
                        end
                        default: nxt = ST_YIELD;
                    endcase
                end
            end
            ST_YIELD: begin
                nxt = win_any ? ST_REQ : ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        hold_req = 1'b0;
        move     = 1'b0;
        idle     = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_REQ:   hold_req = 1'b1;
            ST_XFER: begin
                hold_req = 1'b1;
                move     = hold_ack && ((cur_mode != MODE_DEMAND) || cur_dreq);
            end
            ST_YIELD: hold_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma4_ctrl.sv
`timescale 1ns/1ps
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic [NCH-1:0]    dreq,
    input  logic              hold_ack,
    output logic              hold_req,
    output logic              xfer_stb,
    output logic [NCH-1:0]    dack,
    output logic [NCH-1:0]    done,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    logic [NCH-1:0][ADDR_W-1:0] src_all;
    logic [NCH-1:0][ADDR_W-1:0] dst_all;
    logic [NCH-1:0][CNT_W-1:0]  cnt_all;
    xfer_mode_e                 mode_all [NCH];
    logic [NCH-1:0]             en_all;
    logic [NCH-1:0]             last_all;
    logic [NCH-1:0]             wr_ok;
    logic [NCH-1:0]             step;
    logic [NCH-1:0]             pending;

    logic            seq_idle;
    logic            move;
    logic            win_any;
    logic [CH_W-1:0] win_idx;
    logic [CH_W-1:0] cur_ch;
    xfer_mode_e      sel_mode;
    logic            sel_last;

    assign pending = en_all & dreq;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_ok[i] = cfg_we && (cfg_chan == CH_W'(i)) && seq_idle && !en_all[i];
        assign step[i]  = move && (cur_ch == CH_W'(i));

        dma4_chan #(
            .ADDR_W(ADDR_W),
            .CNT_W (CNT_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_ok[i]),
            .wr_sel (cfg_sel),
            .wr_data(cfg_data),
            .step   (step[i]),
            .src_q  (src_all[i]),
            .dst_q  (dst_all[i]),
            .cnt_q  (cnt_all[i]),
            .en_q   (en_all[i]),
            .mode_q (mode_all[i]),
            .last   (last_all[i])
        );
    end

    dma4_prio #(
        .NCH (NCH),
        .CH_W(CH_W)
    ) u_prio (
        .req(pending),
        .any(win_any),
        .idx(win_idx)
    );

    assign sel_mode = mode_all[cur_ch];
    assign sel_last = last_all[cur_ch];

    dma4_seq #(
        .NCH (NCH),
        .CH_W(CH_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pending),
        .win_any (win_any),
        .win_idx (win_idx),
        .hold_ack(hold_ack),
        .cur_dreq(dreq[cur_ch]),
        .cur_mode(sel_mode),
        .cur_last(sel_last),
        .hold_req(hold_req),
        .move    (move),
        .idle    (seq_idle),
        .cur_q   (cur_ch)
    );

    assign xfer_stb = move;
    assign dack     = step;
    assign done     = step & last_all;
    assign src_addr = move ? src_all[cur_ch] : '0;
    assign dst_addr = move ? dst_all[cur_ch] : '0;
endmodule

// File: rtl/dma4_ctrl_chk.sv
`timescale 1ns/1ps
module dma4_ctrl_chk
    import dma4_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CH_W  = 2,
    parameter int CNT_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      hold_req,
    input logic                      hold_ack,
    input logic                      xfer_stb,
    input logic [NCH-1:0]            dack,
    input logic [NCH-1:0]            done,
    input logic [NCH-1:0]            dreq,
    input logic [CH_W-1:0]           cur_ch,
    input xfer_mode_e                sel_mode,
    input logic                      sel_last,
    input logic [NCH-1:0][CNT_W-1:0] cnt_all,
    input logic [NCH-1:0]            en_all
);
    a_r2_move_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> (hold_ack && hold_req));

    a_r10_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    a_r10_dack_matches_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) == xfer_stb);

    a_r9_done_inside_dack: assert property (@(posedge clk) disable iff (!rst_n)
        (done & ~dack) == '0);

    a_r6_single_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && (sel_mode == MODE_SINGLE || sel_mode == MODE_RSVD)) |=> !hold_req);

    a_r8_demand_needs_dreq: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && sel_mode == MODE_DEMAND) |-> dreq[cur_ch]);

    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |=> (cnt_all[$past(cur_ch)] == $past(cnt_all[cur_ch]) - 1'b1));

    a_r9_tc_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && sel_last) |=> !en_all[$past(cur_ch)]);

    a_r3_move_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> en_all[cur_ch]);
endmodule

bind dma4_ctrl dma4_ctrl_chk #(
    .NCH  (NCH),
    .CH_W (CH_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_req(hold_req),
    .hold_ack(hold_ack),
    .xfer_stb(xfer_stb),
    .dack    (dack),
    .done    (done),
    .dreq    (dreq),
    .cur_ch  (cur_ch),
    .sel_mode(sel_mode),
    .sel_last(sel_last),
    .cnt_all (cnt_all),
    .en_all  (en_all)
);

// File: tb/dma4_ctrl_test.sv
`timescale 1ns/1ps
module dma4_ctrl_test;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 8;

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  mode;
        logic [15:0] src;
        logic [15:0] dst;
        logic [7:0]  cnt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 16'h1000, 16'h2000, 8'd3},
        '{2'd1, 2'd1, 16'h1100, 16'h2100, 8'd5},
        '{2'd2, 2'd2, 16'h1200, 16'h2200, 8'd4},
        '{2'd3, 2'd0, 16'h1300, 16'h2300, 8'd1},
        '{2'd0, 2'd1, 16'h1400, 16'h2400, 8'd1},
        '{2'd3, 2'd2, 16'hFFFE, 16'h00FD, 8'd7},
        '{2'd2, 2'd1, 16'hFFF0, 16'h8000, 8'd40},
        '{2'd1, 2'd3, 16'h1500, 16'h2500, 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_chan = '0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_data = '0;
    logic [NCH-1:0] dreq = '0;
    logic          hold_ack;
    logic          hold_req;
    logic          xfer_stb;
    logic [NCH-1:0] dack;
    logic [NCH-1:0] done;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;

    logic cpu_block = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    logic [AW-1:0] exp_src [NCH];
    logic [AW-1:0] exp_dst [NCH];
    int            exp_rem [NCH];

    int run_xfers, run_dones, run_first, run_last, run_low, run_target;
    logic [AW-1:0] run_first_src;
    int order_log [64];
    int log_n = 0;

    dma4_ctrl #(.NCH(NCH), .ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .dreq(dreq),
        .hold_ack(hold_ack), .hold_req(hold_req), .xfer_stb(xfer_stb),
        .dack(dack), .done(done), .src_addr(src_addr), .dst_addr(dst_addr)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // CPU model: grants one cycle after the request, unless blocked
    initial begin
        hold_ack = 1'b0;
        forever begin
            @(posedge clk);
            hold_ack <= rst_n && hold_req && !cpu_block;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor, sampled at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (xfer_stb) begin
                int ch;
                ch = 0;
                for (int k = 0; k < NCH; k++) if (dack[k]) ch = k;
                chk($countones(dack) == 1, "R10", "dack ones", $countones(dack), 1);
                chk(hold_ack && hold_req, "R2", "handshake at move", {hold_req, hold_ack}, 3);
                chk(src_addr == exp_src[ch], "R5", "src_addr", src_addr, exp_src[ch]);
                chk(dst_addr == exp_dst[ch], "R5", "dst_addr", dst_addr, exp_dst[ch]);
                chk(done == ((exp_rem[ch] == 1) ? (4'b1 << ch) : 4'b0), "R9", "done",
                    done, (exp_rem[ch] == 1) ? (1 << ch) : 0);
                exp_src[ch] = exp_src[ch] + 1'b1;
                exp_dst[ch] = exp_dst[ch] + 1'b1;
                exp_rem[ch] = exp_rem[ch] - 1;
                if (log_n < 64) order_log[log_n] = ch;
                log_n++;
                if (run_xfers == 0) begin
                    run_first = cyc;
                    run_first_src = src_addr;
                end
                run_last = cyc;
                run_xfers++;
                if (done != 0) run_dones++;
            end else begin
                if (dack != 0) chk(1'b0, "R10", "dack without xfer_stb", dack, 0);
                if (done != 0) chk(1'b0, "R10", "done without xfer_stb", done, 0);
                if (src_addr != 0 || dst_addr != 0)
                    chk(1'b0, "R2", "address driven while idle", src_addr, 0);
            end
            if (!hold_req && run_xfers > 0 && run_xfers < run_target) run_low++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input int ch, input int sel, input logic [AW-1:0] data);
        cfg_we   = 1'b1;
        cfg_chan = 2'(ch);
        cfg_sel  = 2'(sel);
        cfg_data = data;
        tick();
        cfg_we   = 1'b0;
    endtask

    task automatic program_ch(input int ch, input int mode, input logic [AW-1:0] s,
                              input logic [AW-1:0] d, input int n);
        cfg_write(ch, 0, s);
        cfg_write(ch, 1, d);
        cfg_write(ch, 2, AW'(n));
        cfg_write(ch, 3, AW'((mode << 1) | 1));
        exp_src[ch] = s;
        exp_dst[ch] = d;
        exp_rem[ch] = n;
    endtask

    task automatic clear_run(input int target);
        run_xfers = 0;
        run_dones = 0;
        run_first = 0;
        run_last  = 0;
        run_low   = 0;
        run_target = target;
        run_first_src = '0;
    endtask

    task automatic wait_done(input int lim);
        for (int k = 0; k < lim && run_dones == 0; k++) tick();
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        for (int k = 0; k < NCH; k++) begin
            exp_src[k] = '0;
            exp_dst[k] = '0;
            exp_rem[k] = 0;
        end
        clear_run(0);

        // R1: reset state, unprogrammed channels ignore requests
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(hold_req == 0, "R1", "hold_req after reset", hold_req, 0);
        chk(xfer_stb == 0 && dack == 0 && done == 0, "R1", "strobes after reset",
            {xfer_stb, dack, done}, 0);
        dreq = '1;
        repeat (5) tick();
        chk(hold_req == 0, "R1", "hold_req with disabled channels", hold_req, 0);
        dreq = '0;
        tick();

        // vector table: one channel per run
        for (int v = 0; v < NV; v++) begin
            int ch, md, n;
            ch = VECS[v].ch;
            md = VECS[v].mode;
            n  = VECS[v].cnt;
            program_ch(ch, md, VECS[v].src, VECS[v].dst, n);
            clear_run(n);
            dreq[ch] = 1'b1;
            wait_done(2000);
            repeat (6) tick();
            chk(run_xfers == n, "R5", "bytes moved in run", run_xfers, n);
            chk(run_dones == 1, "R9", "done pulses in run", run_dones, 1);
            chk(hold_req == 0, "R9", "no service after terminal count", hold_req, 0);
            if (md == 1) begin
                chk(run_last - run_first == n - 1, "R7", "block run span",
                    run_last - run_first, n - 1);
            end else if (md == 2) begin
                chk(run_last - run_first == n - 1, "R8", "demand run span",
                    run_last - run_first, n - 1);
            end else begin
                chk(run_low >= n - 1, "R6", "released cycles between bytes", run_low, n - 1);
                chk(run_last - run_first >= 2 * (n - 1), "R6", "single run span",
                    run_last - run_first, 2 * (n - 1));
            end
            dreq = '0;
            tick();
        end

        // R2 and R4: requests wait for the grant, then fixed priority
        cpu_block = 1'b1;
        for (int c = NCH - 1; c >= 0; c--) program_ch(c, 1, AW'(16'h3000 + c * 16'h100),
                                                      AW'(16'h4000 + c * 16'h100), 2);
        clear_run(8);
        log_n = 0;
        dreq = '1;
        repeat (6) tick();
        chk(hold_req == 1, "R2", "hold_req while waiting", hold_req, 1);
        chk(log_n == 0, "R2", "bytes moved before grant", log_n, 0);
        cpu_block = 1'b0;
        for (int k = 0; k < 200 && log_n < 8; k++) tick();
        for (int k = 0; k < 8; k++)
            chk(order_log[k] == k / 2, "R4", "service order", order_log[k], k / 2);
        dreq = '0;
        repeat (4) tick();

        // R7: dropping the request in block mode changes nothing
        program_ch(1, 1, 16'h5000, 16'h6000, 4);
        clear_run(4);
        dreq[1] = 1'b1;
        for (int k = 0; k < 100 && run_xfers == 0; k++) tick();
        dreq[1] = 1'b0;
        wait_done(100);
        repeat (3) tick();
        chk(run_xfers == 4, "R7", "block bytes after dreq drop", run_xfers, 4);

        // R8: demand pause and resume
        program_ch(2, 2, 16'h5100, 16'h6100, 6);
        clear_run(6);
        dreq[2] = 1'b1;
        for (int k = 0; k < 100 && run_xfers < 3; k++) tick();
        dreq[2] = 1'b0;
        repeat (5) tick();
        chk(run_xfers == 3, "R8", "bytes before request drop", run_xfers, 3);
        chk(hold_req == 0, "R8", "bus released after drop", hold_req, 0);
        dreq[2] = 1'b1;
        wait_done(100);
        repeat (3) tick();
        chk(run_xfers == 6, "R8", "bytes after resume", run_xfers, 6);
        chk(run_dones == 1, "R9", "done after resume", run_dones, 1);
        dreq = '0;
        tick();

        // R3: writes to an active channel are ignored
        program_ch(2, 1, 16'h0300, 16'h0400, 3);
        cfg_write(2, 0, 16'h7777);
        cfg_write(2, 3, 16'h0000);
        clear_run(3);
        dreq[2] = 1'b1;
        wait_done(100);
        repeat (3) tick();
        chk(run_first_src == 16'h0300, "R3", "src after ignored write", run_first_src, 16'h0300);
        chk(run_xfers == 3, "R3", "bytes after ignored disable", run_xfers, 3);
        dreq = '0;
        tick();

        // R3: writes while the bus is owned are ignored
        cfg_write(3, 0, 16'h0500);
        cfg_write(3, 1, 16'h0600);
        cfg_write(3, 2, 16'd2);
        exp_src[3] = 16'h0500;
        exp_dst[3] = 16'h0600;
        exp_rem[3] = 2;
        program_ch(1, 1, 16'h0700, 16'h0800, 6);
        clear_run(6);
        dreq[1] = 1'b1;
        for (int k = 0; k < 100 && run_xfers == 0; k++) tick();
        cfg_write(3, 0, 16'h0999);
        wait_done(100);
        dreq = '0;
        repeat (3) tick();
        cfg_write(3, 3, 16'h0003);
        clear_run(2);
        dreq[3] = 1'b1;
        wait_done(100);
        repeat (3) tick();
        chk(run_first_src == 16'h0500, "R3", "src after busy-time write", run_first_src, 16'h0500);
        chk(run_xfers == 2, "R3", "bytes of re-enabled channel", run_xfers, 2);
        dreq = '0;
        tick();

        // R3: enabling with a zero count leaves the channel off
        cfg_write(0, 2, 16'd0);
        cfg_write(0, 3, 16'h0003);
        clear_run(0);
        dreq[0] = 1'b1;
        repeat (8) tick();
        chk(hold_req == 0, "R3", "hold_req with zero count", hold_req, 0);
        chk(run_xfers == 0, "R3", "bytes with zero count", run_xfers, 0);
        dreq = '0;
        tick();

        summary();
    end
endmodule